// File: doc/BRIEF.md
# Vertical Interval Timing Decoder

This block keeps the position inside a 2:1 interlaced television frame and decodes it into the vertical timing outputs. Those outputs are vertical drive, vertical processing blanking, short vertical drive and a frame sync pulse that marks the start of the odd field. The master clock runs at 32 clocks per line. The position is held as a half-line index and a clock phase of 16 clocks inside that half-line. In the 525-line standard the frame has 1050 half-lines and in the 625-line standard it has 1250. Field 1 starts at half-line 0, the first equalizing pulse. Field 2 starts half a frame later, at half-line index equal to the line count.

Every vertical output is a window in frame clocks. It rises LEAD (1) clock after the half-line boundary where it starts and falls TRAIL (2) clocks after the half-line boundary where it ends. Two active-low load inputs let an external reference slave the count. One holds the position at the first equalizing pulse. The other holds it at the first vertical sync pulse, which is line 3. Each load input passes through a two-flop synchronizer first.

Top module: `vtim_decoder`

## Requirements
- R1: While `rst_n` is low, all four outputs are 0 and the position is clock 0 of half-line 0.
- R2: The position advances one clock per cycle and wraps after 32 x N clocks, where N is 525 when `std_625`=0 and 625 when `std_625`=1. Frame sync pulses are therefore 16800 or 20000 cycles apart.
- R3: `vdrive_o` is high in field 1 from line 0 to the start of line 10. In field 2 it is high from half-line N to the start of line floor(N/2)+9, which is line 271 or 321.
- R4: `vblank_o` is high in field 1 from line 0 to the start of line 22. In field 2 it is high from half-line N to the start of line floor(N/2)+21, which is line 283 or 333.
- R5: `svdrive_o` is high over lines 3 to 6 in field 1. In field 2 it is high over half-lines N+6 to N+12, which is lines 265.5 to 268.5 or 315.5 to 318.5.
- R6: `fsync_o` is a pulse of 1 clock at the first equalizing pulse of field 1 only, at frame clock 1. It is never high in field 2.
- R7: Every window rises 1 clock after its starting half-line boundary and falls 2 clocks after its ending boundary. Outputs are registered and show the decode of the position held before the same clock edge.
- R8: A low on `eq_load_n` that is sampled at edge k holds the position at frame clock 0 from edge k+2 on. After release, counting resumes from frame clock 0.
- R9: A low on `vs_load_n` that is sampled at edge k holds the position at frame clock 96, the start of line 3, from edge k+2 on. After release, counting resumes from that point.
- R10: When both load inputs are low, `eq_load_n` wins and the position is held at frame clock 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 32 per line |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_625 | input | 1 | 0: 525-line frame, 1: 625-line frame |
| eq_load_n | input | 1 | Active-low hold at the first equalizing pulse (frame clock 0) |
| vs_load_n | input | 1 | Active-low hold at the first vertical sync pulse (line 3) |
| vdrive_o | output | 1 | Vertical drive |
| vblank_o | output | 1 | Vertical processing blanking |
| svdrive_o | output | 1 | Short vertical drive |
| fsync_o | output | 1 | Odd-field frame sync pulse |

## Verification
Each output is due one cycle after the position that produces it. A change on a load input reaches the position at the second edge after it is sampled and reaches the outputs one edge after that. The bench has a model that advances at each rising edge and pushes the outputs expected for the position held before that edge. A monitor pops each expected item at the next falling edge, which is where the registered outputs of that edge are stable. The model delays each load input through two bench variables, so the two-edge latency is counted rather than copied from the design. Directed checks cover the first rising and falling edges of the windows after reset and the spacing of frame sync pulses in both line standards.

// File: rtl/vtim_pkg.sv
package vtim_pkg;

  // Where the next position comes from
  typedef enum logic [1:0] {
    SRC_RUN = 2'd0,
    SRC_EQ  = 2'd1,
    SRC_VS  = 2'd2
  } vtim_src_e;

  // Lines in the frame selected by the standard input
  function automatic int frame_lines(input logic std_b, input int lines_a, input int lines_b);
    return std_b ? lines_b : lines_a;
  endfunction

  // Frame clock index of an edge placed off clocks after a half-line boundary
  function automatic logic [31:0] edge_clock(input int half, input int half_clks, input int off);
    return 32'(half * half_clks + off);
  endfunction

  // Half-line index where a field-2 window ends, for a field-1 end line
  function automatic int field2_end_half(input int lines, input int end_line);
    return 2 * ((lines / 2) + end_line - 1);
  endfunction

endpackage

// File: rtl/vtim_sync.sv
module vtim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_n,
  output logic q_n
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= d_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], d_n};
      end
    end
  endgenerate

  assign q_n = sh_q[STAGES-1];
endmodule

// File: rtl/vtim_position.sv
module vtim_position
  import vtim_pkg::*;
#(
  parameter int HL_W      = 11,
  parameter int PH_W      = 4,
  parameter int HALF_CLKS = 16,
  parameter int VS_HALF   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HL_W-1:0] last_hl_i,
  input  logic            eq_hold_n,
  input  logic            vs_hold_n,
  output logic [HL_W-1:0] hl_o,
  output logic [PH_W-1:0] ph_o,
  output vtim_src_e       src_o,
  output logic            wrap_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_CLKS - 1);
  localparam logic [HL_W-1:0] HL_VS   = HL_W'(VS_HALF);

  logic [HL_W-1:0] hl_q;
  logic [PH_W-1:0] ph_q;
  logic            ph_last;
  logic            hl_last;

  always_comb begin
    if (!eq_hold_n)      src_o = SRC_EQ;
    else if (!vs_hold_n) src_o = SRC_VS;
    else                 src_o = SRC_RUN;
  end

  assign ph_last = (ph_q == PH_LAST);
  assign hl_last = (hl_q >= last_hl_i);
  assign wrap_o  = (src_o == SRC_RUN) && ph_last && hl_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl_q <= '0;
      ph_q <= '0;
    end else begin
      unique case (src_o)
        SRC_EQ: begin
          hl_q <= '0;
          ph_q <= '0;
        end
        SRC_VS: begin
          hl_q <= HL_VS;
          ph_q <= '0;
        end
        default: begin
          if (ph_last) begin
            ph_q <= '0;
            hl_q <= hl_last ? '0 : hl_q + 1'b1;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign hl_o = hl_q;
  assign ph_o = ph_q;
endmodule

// File: rtl/vtim_window.sv
module vtim_window #(
  parameter int NSPAN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] pos_i,
  input  logic [31:0] lo_i [NSPAN],
  input  logic [31:0] hi_i [NSPAN],
  output logic        win_o
);
  logic [NSPAN-1:0] hit;

  for (genvar s = 0; s < NSPAN; s++) begin : g_span
    assign hit[s] = (pos_i >= lo_i[s]) && (pos_i < hi_i[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_o <= 1'b0;
    else        win_o <= |hit;
  end
endmodule

// File: rtl/vtim_decoder.sv
module vtim_decoder
  import vtim_pkg::*;
#(
  parameter int LINES_A        = 525,
  parameter int LINES_B        = 625,
  parameter int LINE_CLKS      = 32,
  parameter int LEAD           = 1,
  parameter int TRAIL          = 2,
  parameter int VD_END_LINE    = 10,
  parameter int VB_END_LINE    = 22,
  parameter int SVD_FIRST_LINE = 3,
  parameter int SVD_END_LINE   = 6,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic std_625,
  input  logic eq_load_n,
  input  logic vs_load_n,
  output logic vdrive_o,
  output logic vblank_o,
  output logic svdrive_o,
  output logic fsync_o
);
  localparam int HALF_CLKS = LINE_CLKS / 2;
  localparam int PH_W      = $clog2(HALF_CLKS);
  localparam int MAX_LINES = (LINES_A > LINES_B) ? LINES_A : LINES_B;
  localparam int HL_W      = $clog2(2 * MAX_LINES);
  localparam int VS_HALF   = 2 * SVD_FIRST_LINE;
  localparam int NWIN      = 3;
  localparam int NSPAN     = 2;

  // Window order: vertical drive, vertical blanking, short vertical drive
  localparam int W_VD  = 0;
  localparam int W_VB  = 1;
  localparam int W_SVD = 2;

  logic            eq_sync_n;
  logic            vs_sync_n;
  logic [HL_W-1:0] hl;
  logic [PH_W-1:0] ph;
  logic [HL_W-1:0] last_hl;
  vtim_src_e       src;
  logic            wrap;
  logic [31:0]     pos;
  logic            frame_origin;
  logic [31:0]     span_lo [NWIN][NSPAN];
  logic [31:0]     span_hi [NWIN][NSPAN];
  logic [NWIN-1:0] win;
  int              half_lo [NWIN][NSPAN];
  int              half_hi [NWIN][NSPAN];
  int              nl;

  vtim_sync #(.STAGES(SYNC_STAGES)) i_eq_sync (
    .clk(clk), .rst_n(rst_n), .d_n(eq_load_n), .q_n(eq_sync_n)
  );

  vtim_sync #(.STAGES(SYNC_STAGES)) i_vs_sync (
    .clk(clk), .rst_n(rst_n), .d_n(vs_load_n), .q_n(vs_sync_n)
  );

  assign nl      = frame_lines(std_625, LINES_A, LINES_B);
  assign last_hl = HL_W'(2 * nl - 1);

  vtim_position #(
    .HL_W(HL_W), .PH_W(PH_W), .HALF_CLKS(HALF_CLKS), .VS_HALF(VS_HALF)
  ) i_position (
    .clk(clk), .rst_n(rst_n), .last_hl_i(last_hl),
    .eq_hold_n(eq_sync_n), .vs_hold_n(vs_sync_n),
    .hl_o(hl), .ph_o(ph), .src_o(src), .wrap_o(wrap)
  );

  assign pos = 32'(hl) * 32'(HALF_CLKS) + 32'(ph);

  // Half-line bounds of each window in each field
  always_comb begin
    half_lo[W_VD][0]  = 0;
    half_hi[W_VD][0]  = 2 * VD_END_LINE;
    half_lo[W_VD][1]  = nl;
    half_hi[W_VD][1]  = field2_end_half(nl, VD_END_LINE);
    half_lo[W_VB][0]  = 0;
    half_hi[W_VB][0]  = 2 * VB_END_LINE;
    half_lo[W_VB][1]  = nl;
    half_hi[W_VB][1]  = field2_end_half(nl, VB_END_LINE);
    half_lo[W_SVD][0] = 2 * SVD_FIRST_LINE;
    half_hi[W_SVD][0] = 2 * SVD_END_LINE;
    half_lo[W_SVD][1] = nl + 2 * SVD_FIRST_LINE;
    half_hi[W_SVD][1] = nl + 2 * SVD_END_LINE;
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    for (genvar f = 0; f < NSPAN; f++) begin : g_field
      assign span_lo[w][f] = edge_clock(half_lo[w][f], HALF_CLKS, LEAD);
      assign span_hi[w][f] = edge_clock(half_hi[w][f], HALF_CLKS, TRAIL);
    end
    vtim_window #(.NSPAN(NSPAN)) i_window (
      .clk(clk), .rst_n(rst_n), .pos_i(pos),
      .lo_i(span_lo[w]), .hi_i(span_hi[w]), .win_o(win[w])
    );
  end

  assign frame_origin = (pos == 32'(LEAD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsync_o <= 1'b0;
    else        fsync_o <= frame_origin;
  end

  assign vdrive_o  = win[W_VD];
  assign vblank_o  = win[W_VB];
  assign svdrive_o = win[W_SVD];
endmodule

// File: rtl/vtim_checker.sv
module vtim_checker
  import vtim_pkg::*;
#(
  parameter int HL_W      = 11,
  parameter int PH_W      = 4,
  parameter int HALF_CLKS = 16,
  parameter int VS_HALF   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [HL_W-1:0] hl,
  input logic [PH_W-1:0] ph,
  input vtim_src_e       src,
  input logic            wrap,
  input logic            eq_sync_n,
  input logic            vs_sync_n,
  input logic            vd,
  input logic            vb,
  input logic            svd,
  input logic            fs
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_CLKS - 1);

  // R2
  ph_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_RUN && ph != PH_LAST) |=> (ph == $past(ph) + 1'b1 && hl == $past(hl)));

  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (hl == '0 && ph == '0));

  // R8
  eq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eq_sync_n |=> (hl == '0 && ph == '0));

  // R9
  vs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_sync_n && !vs_sync_n) |=> (hl == HL_W'(VS_HALF) && ph == '0));

  // R10
  load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eq_sync_n && !vs_sync_n) |=> (hl == '0));

  // R6
  fsync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs |=> !fs);

  // R6
  fsync_in_vd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs |-> (vd && vb));

  // R5
  svd_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svd |-> vd);

  // R3
  vd_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vd |-> vb);
endmodule

bind vtim_decoder vtim_checker #(
  .HL_W(HL_W), .PH_W(PH_W), .HALF_CLKS(HALF_CLKS), .VS_HALF(VS_HALF)
) i_vtim_checker (
  .clk(clk), .rst_n(rst_n), .hl(hl), .ph(ph), .src(src), .wrap(wrap),
  .eq_sync_n(eq_sync_n), .vs_sync_n(vs_sync_n),
  .vd(vdrive_o), .vb(vblank_o), .svd(svdrive_o), .fs(fsync_o)
);

// File: tb/test_vtim_decoder.sv
module test_vtim_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic std_625 = 1'b0;
  logic eq_load_n = 1'b1;
  logic vs_load_n = 1'b1;
  logic vdrive_o, vblank_o, svdrive_o, fsync_o;

  always #10 clk = ~clk;  // 50 MHz

  vtim_decoder i_vtim_decoder (
    .clk(clk), .rst_n(rst_n), .std_625(std_625),
    .eq_load_n(eq_load_n), .vs_load_n(vs_load_n),
    .vdrive_o(vdrive_o), .vblank_o(vblank_o),
    .svdrive_o(svdrive_o), .fsync_o(fsync_o)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  logic [3:0] expq[$];
  logic [3:0] mexp;
  int mc;
  logic p1e, p2e, p1v, p2v;
  int cyc;
  int first_vd, first_vd_fall, first_svd;
  int last_fs;
  bit measure = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) %s: actual=%0d expected=%0d", req, tag, what, act, exp);
    end
  endtask

  function automatic bit inw(input int x, input int lo, input int hi);
    return x >= lo && x < hi;
  endfunction

  // Expected {vd, vb, svd, fs} for frame clock x in a frame of l lines
  function automatic logic [3:0] model_out(input int x, input int l);
    int f2;
    logic a, b, s, f;
    f2 = l * 16;
    a = inw(x, 1, 10 * 32 + 2) || inw(x, f2 + 1, ((l / 2) + 9) * 32 + 2);
    b = inw(x, 1, 22 * 32 + 2) || inw(x, f2 + 1, ((l / 2) + 21) * 32 + 2);
    s = inw(x, 3 * 32 + 1, 6 * 32 + 2) || inw(x, f2 + 3 * 32 + 1, f2 + 6 * 32 + 2);
    f = (x == 1);
    return {a, b, s, f};
  endfunction

  // Driver: model advances at each edge and queues the result due at the next falling edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mc = 0; p1e = 1'b1; p2e = 1'b1; p1v = 1'b1; p2v = 1'b1;
    end else begin
      int l;
      l = std_625 ? 625 : 525;
      expq.push_back(model_out(mc, l));
      if (!p2e)      mc = 0;                   // R8, R10
      else if (!p2v) mc = 3 * 32;              // R9
      else           mc = (mc + 1) % (l * 32); // R2
      p2e = p1e; p1e = eq_load_n;
      p2v = p1v; p1v = vs_load_n;
    end
  end

  // Monitor
  always @(negedge clk) begin
    if (rst_n && expq.size() > 0) begin
      mexp = expq.pop_front();
      cyc++;
      chk(vdrive_o  == mexp[3], "R3", "vdrive",  int'(vdrive_o),  int'(mexp[3]));
      chk(vblank_o  == mexp[2], "R4", "vblank",  int'(vblank_o),  int'(mexp[2]));
      chk(svdrive_o == mexp[1], "R5", "svdrive", int'(svdrive_o), int'(mexp[1]));
      chk(fsync_o   == mexp[0], "R6", "fsync",   int'(fsync_o),   int'(mexp[0]));
      if (vdrive_o && first_vd < 0) first_vd = cyc;
      if (!vdrive_o && first_vd >= 0 && first_vd_fall < 0) first_vd_fall = cyc;
      if (svdrive_o && first_svd < 0) first_svd = cyc;
      if (fsync_o) begin
        if (measure && last_fs >= 0)
          chk(cyc - last_fs == (std_625 ? 20000 : 16800), "R2", "fsync spacing",
              cyc - last_fs, std_625 ? 20000 : 16800);
        last_fs = cyc;
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset(input logic std);
    @(posedge clk); #2;
    rst_n = 1'b0;
    expq.delete();
    std_625 = std;
    eq_load_n = 1'b1; vs_load_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk({vdrive_o, vblank_o, svdrive_o, fsync_o} == 4'b0, "R1", "outputs in reset",
        int'({vdrive_o, vblank_o, svdrive_o, fsync_o}), 0);
    cyc = 0; first_vd = -1; first_vd_fall = -1; first_svd = -1; last_fs = -1;
    @(posedge clk); #2;
    rst_n = 1'b1;
  endtask

  initial begin
    tag = "R1";
    do_reset(1'b0);
    tag = "R2";
    measure = 1;
    run(33700);
    measure = 0;
    // R7
    chk(first_vd == 2, "R7", "first vdrive high sample", first_vd, 2);
    chk(first_vd_fall == 323, "R7", "first vdrive low sample", first_vd_fall, 323);
    chk(first_svd == 98, "R7", "first svdrive high sample", first_svd, 98);

    tag = "R8";
    eq_load_n = 1'b0; run(50);
    eq_load_n = 1'b1; run(2000);

    tag = "R9";
    run(3000);
    vs_load_n = 1'b0; run(40);
    vs_load_n = 1'b1; run(2000);

    tag = "R10";
    run(1500);
    eq_load_n = 1'b0; vs_load_n = 1'b0; run(30);
    eq_load_n = 1'b1; run(30);
    vs_load_n = 1'b1; run(2000);

    tag = "R2";
    do_reset(1'b1);
    measure = 1;
    run(40100);
    measure = 0;

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(150000 * 20);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog (%s): actual=timeout expected=completion", tag);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule